// File: doc/BRIEF.md
# Locked Read-Modify-Write Bus Master

This block is a bus-master sequencer for a 32-bit bus whose cycles are paced by an asynchronous two-bit acknowledge. A requester presents a kind, an address, a function code, an operand and a byte-lane mask. The block then runs a read cycle, a write cycle, or an indivisible read-then-write pair. Each bus cycle walks through six phases, S0 to S5, and one phase lasts one tick of `clk`. `clk` therefore runs at twice the bus clock rate. The phase that ends at a falling bus-clock edge is the one in which the acknowledge is judged: S2, and the first tick of every inserted wait pair.

For a read-modify-write, the value read is combined with the operand by a combinational modify function. The function is chosen by a parameter and defaults to bitwise OR. The result is written back to the same address after a short run of idle ticks, and a lock output keeps other masters off the bus for the whole pair. The acknowledge passes through a flop synchronizer. It is recognized only when the last two stages agree that a line is low, so a level that is still settling counts as negated. A one-cycle done pulse returns the captured read data.

Top module: `abus_rmw_master`

## Requirements
- R1: While reset is held, every strobe output (`bus_as_n`, `bus_ds_n`, `bus_oe_n`, `bus_we_n`, `bus_lock_n`) is high, `bus_rw` is high (read level), `bus_dout_en` is low, `done_o` is low and `req_ready` is high.
- R2: `req_ready` is high only when no transfer is in progress. A `req_valid` pulse while `req_ready` is low is ignored: it starts no bus cycle and alters no memory word.
- R3: In a read cycle, address strobe, data strobe and output enable assert together from S1 and negate in S5. They assert only while `bus_rw` is high. `bus_din` is captured at the end of S4 and presented on `rdata_o` with the done pulse.
- R4: In a write cycle, `bus_rw` goes low in S0. Address strobe and the selected write enables assert together in S1. `bus_dout_en` rises in S2, before the data strobe asserts in S3. All strobes negate in S5, while address, data, `bus_rw` and function code stay valid through S5.
- R5: An acknowledge not recognized by the end of S2 causes wait ticks in pairs after S3. Recognition is tested at the end of the first tick of each pair, and S4 follows the pair in which it succeeds. A slower responder therefore keeps address strobe low for more ticks.
- R6: A read-modify-write drives two address-strobe assertions, a read and then a write, to the same address. Between them come `GAP_TICKS` idle ticks with no strobe asserted and `bus_rw` held high. `bus_lock_n` stays low from the read S0 through the write S5.
- R7: The write value of a read-modify-write is the modify function of the read data and the operand; the default function is bitwise OR. Lane mask bit i drives `bus_we_n[i]` low and covers data bits 8i+7 down to 8i. Unselected bytes are left untouched.
- R8: `req_kind` is encoded as 0 = read only, 1 = write only, 2 = read-modify-write. A read only or write only request produces exactly one address-strobe assertion and leaves `bus_lock_n` high.
- R9: `done_o` pulses for exactly one cycle after the final S5 of a request, and the block is idle in that cycle.
- R10: An acknowledge low for a single `clk` cycle is not recognized and does not end the bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock, two ticks per bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request will be taken |
| req_kind | input | 2 | 0 read, 1 write, 2 read-modify-write |
| req_addr | input | AW | Transfer address |
| req_fc | input | 4 | Function code for the transfer |
| req_wdata | input | 32 | Write data or modify operand |
| req_lanes | input | 4 | Byte lanes to write |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 32 | Data captured in the read portion |
| bus_addr | output | AW | Bus address |
| bus_fc | output | 4 | Bus function code |
| bus_rw | output | 1 | High read, low write |
| bus_as_n | output | 1 | Address strobe, active low |
| bus_ds_n | output | 1 | Data strobe, active low |
| bus_oe_n | output | 1 | Output enable, active low |
| bus_we_n | output | 4 | Byte write enables, active low |
| bus_lock_n | output | 1 | Bus lock, active low |
| bus_dout | output | 32 | Write data |
| bus_dout_en | output | 1 | Write data driven |
| bus_din | input | 32 | Read data from the bus |
| bus_ack_n | input | 2 | Asynchronous acknowledge, active low |

## Verification
The assertions assume that the responder releases its acknowledge soon after address strobe negates, so that no stale acknowledge reaches the next cycle's S2 sample. They also assume that `bus_din` is stable around the end of S4. The bench's responder model drops the acknowledge at the first falling edge on which it sees address strobe high, and it presents the memory word for the current address. When the responder is switched off, the manual acknowledge is released once the cycle has ended. Read data is stable because memory changes only through write-enabled lanes or a preload between requests.

// File: rtl/abus_pkg.sv
package abus_pkg;

  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_RMW   = 2'd2
  } kind_e;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_S0,
    PH_S1,
    PH_S2,
    PH_S3,
    PH_S4,
    PH_S5,
    PH_WH,
    PH_WL,
    PH_GAP
  } phase_e;

  // phases during which the address strobe is active
  function automatic logic ph_strobe(phase_e p);
    return (p == PH_S1) || (p == PH_S2) || (p == PH_S3) ||
           (p == PH_WH) || (p == PH_WL) || (p == PH_S4);
  endfunction

  // phases during which a write drives its data strobe
  function automatic logic ph_wr_ds(phase_e p);
    return (p == PH_S3) || (p == PH_WH) || (p == PH_WL) || (p == PH_S4);
  endfunction

  // phases during which write data is on the bus
  function automatic logic ph_wr_data(phase_e p);
    return (p == PH_S2) || (p == PH_S3) || (p == PH_WH) ||
           (p == PH_WL) || (p == PH_S4) || (p == PH_S5);
  endfunction

endpackage

// File: rtl/abus_ack_sync.sv
module abus_ack_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ack_n_i,
  output logic         seen_o
);

  logic [STAGES-1:0][W-1:0] stage_q;
  logic [STAGES-1:0][W-1:0] stage_d;

  always_comb begin
    stage_d[0] = ~ack_n_i;
    for (int s = 1; s < STAGES; s++) begin
      stage_d[s] = stage_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  // a line counts only when the last two stages agree it is asserted
  assign seen_o = |(stage_q[STAGES-1] & stage_q[STAGES-2]);

endmodule

// File: rtl/abus_modify.sv
module abus_modify #(
  parameter int DW     = 32,
  parameter int MOD_OP = 0   // 0 OR, 1 AND, 2 XOR, 3 ADD
) (
  input  logic [DW-1:0] rd_i,
  input  logic [DW-1:0] opnd_i,
  output logic [DW-1:0] wr_o
);

  generate
    if (MOD_OP == 1) begin : g_and
      assign wr_o = rd_i & opnd_i;
    end else if (MOD_OP == 2) begin : g_xor
      assign wr_o = rd_i ^ opnd_i;
    end else if (MOD_OP == 3) begin : g_add
      assign wr_o = rd_i + opnd_i;
    end else begin : g_or
      assign wr_o = rd_i | opnd_i;
    end
  endgenerate

endmodule

// File: rtl/abus_seq.sv
module abus_seq
  import abus_pkg::*;
#(
  parameter int GAP_TICKS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [1:0] kind_i,
  input  logic       ack_i,
  output phase_e     phase_o,
  output logic       wr_part_o,
  output logic       rmw_o,
  output logic       finish_o,
  output logic       capture_o
);

  localparam int GW = $clog2(GAP_TICKS + 1);

  phase_e          phase_q, phase_d;
  logic            wr_q, wr_d;
  logic            rmw_q, rmw_d;
  logic            ackf_q, ackf_d;
  logic [GW-1:0]   gap_q, gap_d;
  logic            finish;

  always_comb begin
    phase_d = phase_q;
    wr_d    = wr_q;
    rmw_d   = rmw_q;
    ackf_d  = ackf_q;
    gap_d   = gap_q;
    finish  = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (start_i) begin
          phase_d = PH_S0;
          wr_d    = (kind_i == KIND_WRITE);
          rmw_d   = (kind_i == KIND_RMW);
        end
      end
      PH_S0: begin
        ackf_d  = 1'b0;
        phase_d = PH_S1;
      end
      PH_S1: phase_d = PH_S2;
      PH_S2: begin
        ackf_d  = ack_i;
        phase_d = PH_S3;
      end
      PH_S3: phase_d = ackf_q ? PH_S4 : PH_WH;
      PH_WH: begin
        ackf_d  = ack_i;
        phase_d = PH_WL;
      end
      PH_WL: phase_d = ackf_q ? PH_S4 : PH_WH;
      PH_S4: phase_d = PH_S5;
      PH_S5: begin
        if (rmw_q && !wr_q) begin
          phase_d = PH_GAP;
          gap_d   = GW'(GAP_TICKS - 1);
        end else begin
          phase_d = PH_IDLE;
          wr_d    = 1'b0;
          rmw_d   = 1'b0;
          finish  = 1'b1;
        end
      end
      PH_GAP: begin
        if (gap_q == '0) begin
          phase_d = PH_S0;
          wr_d    = 1'b1;
        end else begin
          gap_d = gap_q - 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      wr_q    <= 1'b0;
      rmw_q   <= 1'b0;
      ackf_q  <= 1'b0;
      gap_q   <= '0;
    end else begin
      phase_q <= phase_d;
      wr_q    <= wr_d;
      rmw_q   <= rmw_d;
      ackf_q  <= ackf_d;
      gap_q   <= gap_d;
    end
  end

  assign phase_o   = phase_q;
  assign wr_part_o = wr_q;
  assign rmw_o     = rmw_q;
  assign finish_o  = finish;
  assign capture_o = (phase_q == PH_S4) && !wr_q;

endmodule

// File: rtl/abus_rmw_master.sv
module abus_rmw_master
  import abus_pkg::*;
#(
  parameter int AW          = 32,
  parameter int GAP_TICKS   = 2,
  parameter int SYNC_STAGES = 2,
  parameter int MOD_OP      = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_kind,
  input  logic [AW-1:0] req_addr,
  input  logic [3:0]    req_fc,
  input  logic [31:0]   req_wdata,
  input  logic [3:0]    req_lanes,
  output logic          done_o,
  output logic [31:0]   rdata_o,
  output logic [AW-1:0] bus_addr,
  output logic [3:0]    bus_fc,
  output logic          bus_rw,
  output logic          bus_as_n,
  output logic          bus_ds_n,
  output logic          bus_oe_n,
  output logic [3:0]    bus_we_n,
  output logic          bus_lock_n,
  output logic [31:0]   bus_dout,
  output logic          bus_dout_en,
  input  logic [31:0]   bus_din,
  input  logic [1:0]    bus_ack_n
);

  localparam int DW    = 32;
  localparam int LANES = DW / 8;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  phase_e phase;
  logic   wr_part, rmw, finish, capture, ack_seen;
  logic   accept, busy;

  assign busy      = (phase != PH_IDLE);
  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;

  abus_ack_sync #(
    .W      (2),
    .STAGES (SYNC_STAGES)
  ) i_sync (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .ack_n_i (bus_ack_n),
    .seen_o  (ack_seen)
  );

  abus_seq #(
    .GAP_TICKS (GAP_TICKS)
  ) i_seq (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .start_i   (accept),
    .kind_i    (req_kind),
    .ack_i     (ack_seen),
    .phase_o   (phase),
    .wr_part_o (wr_part),
    .rmw_o     (rmw),
    .finish_o  (finish),
    .capture_o (capture)
  );

  // request and data registers
  logic [AW-1:0]    addr_q;
  logic [3:0]       fc_q;
  logic [DW-1:0]    opnd_q;
  logic [LANES-1:0] lanes_q;
  logic [DW-1:0]    rd_q;
  logic             done_q;
  logic [DW-1:0]    mod_out;

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      addr_q  <= '0;
      fc_q    <= '0;
      opnd_q  <= '0;
      lanes_q <= '0;
      rd_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      if (accept) begin
        addr_q  <= req_addr;
        fc_q    <= req_fc;
        opnd_q  <= req_wdata;
        lanes_q <= req_lanes;
      end
      if (capture) begin
        rd_q <= bus_din;
      end
      done_q <= finish;
    end
  end

  abus_modify #(
    .DW     (DW),
    .MOD_OP (MOD_OP)
  ) i_mod (
    .rd_i   (rd_q),
    .opnd_i (opnd_q),
    .wr_o   (mod_out)
  );

  // bus decode from the registered phase
  logic strobe, wr_active;
  assign strobe    = ph_strobe(phase);
  assign wr_active = busy && wr_part;

  assign bus_addr    = addr_q;
  assign bus_fc      = fc_q;
  assign bus_rw      = !wr_active;
  assign bus_as_n    = !strobe;
  assign bus_oe_n    = !(strobe && !wr_part);
  assign bus_ds_n    = wr_part ? !ph_wr_ds(phase) : !strobe;
  assign bus_lock_n  = !(busy && rmw);
  assign bus_dout_en = wr_active && ph_wr_data(phase);
  assign bus_dout    = rmw ? mod_out : opnd_q;

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign bus_we_n[l] = !(wr_part && strobe && lanes_q[l]);
    end
  endgenerate

  assign done_o  = done_q;
  assign rdata_o = rd_q;

endmodule

// File: rtl/abus_rmw_checker.sv
module abus_rmw_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          done_o,
  input logic [AW-1:0] bus_addr,
  input logic          bus_rw,
  input logic          bus_as_n,
  input logic          bus_ds_n,
  input logic          bus_oe_n,
  input logic [3:0]    bus_we_n,
  input logic          bus_lock_n,
  input logic          bus_dout_en
);

  // R4: byte write enables never appear without the address strobe
  p_we_with_as_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we_n != 4'hF) |-> !bus_as_n);

  // R3: output enable only at read level
  p_oe_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe_n |-> bus_rw);

  // R4: write data is driven only at write level
  p_drive_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_dout_en |-> !bus_rw);

  // R4: a write data strobe always finds the data on the bus
  p_ds_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_ds_n && !bus_rw) |-> bus_dout_en);

  // R3: direction stays put while the address strobe is held
  p_rw_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_as_n && $past(!bus_as_n)) |-> $stable(bus_rw));

  // R6: address held for the whole locked pair
  p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_lock_n && $past(!bus_lock_n)) |-> $stable(bus_addr));

  // R9: completion is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R2: completion is reported while idle
  p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> req_ready);

endmodule

bind abus_rmw_master abus_rmw_checker #(.AW(AW)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .done_o      (done_o),
  .bus_addr    (bus_addr),
  .bus_rw      (bus_rw),
  .bus_as_n    (bus_as_n),
  .bus_ds_n    (bus_ds_n),
  .bus_oe_n    (bus_oe_n),
  .bus_we_n    (bus_we_n),
  .bus_lock_n  (bus_lock_n),
  .bus_dout_en (bus_dout_en)
);

// File: tb/test_abus_rmw_master.sv
module test_abus_rmw_master;

  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_kind = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [3:0]    req_fc = 4'h5;
  logic [31:0]   req_wdata = '0;
  logic [3:0]    req_lanes = 4'h0;
  logic          done_o;
  logic [31:0]   rdata_o;
  logic [AW-1:0] bus_addr;
  logic [3:0]    bus_fc;
  logic          bus_rw, bus_as_n, bus_ds_n, bus_oe_n, bus_lock_n, bus_dout_en;
  logic [3:0]    bus_we_n;
  logic [31:0]   bus_dout;
  logic [31:0]   bus_din;
  logic [1:0]    bus_ack_n;

  always #10 clk = ~clk;

  abus_rmw_master #(.AW(AW)) i_abus_rmw_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .req_fc(req_fc),
    .req_wdata(req_wdata), .req_lanes(req_lanes), .done_o(done_o),
    .rdata_o(rdata_o), .bus_addr(bus_addr), .bus_fc(bus_fc), .bus_rw(bus_rw),
    .bus_as_n(bus_as_n), .bus_ds_n(bus_ds_n), .bus_oe_n(bus_oe_n),
    .bus_we_n(bus_we_n), .bus_lock_n(bus_lock_n), .bus_dout(bus_dout),
    .bus_dout_en(bus_dout_en), .bus_din(bus_din), .bus_ack_n(bus_ack_n)
  );

  // ---------------- responder model ----------------
  logic [31:0] mem [16];
  logic        slave_en = 1'b1;
  logic [1:0]  sl_ack_n = 2'b11;
  logic [1:0]  man_ack_n = 2'b11;
  int          sl_delay = 0;
  int          sl_cnt = 0;
  logic        ld_go = 1'b0;
  logic [3:0]  ld_idx = '0;
  logic [31:0] ld_val = '0;

  assign bus_ack_n = slave_en ? sl_ack_n : man_ack_n;
  assign bus_din   = mem[bus_addr[5:2]];

  always @(negedge clk) begin
    if (ld_go) mem[ld_idx] = ld_val;
    if (!bus_as_n) begin
      sl_cnt = sl_cnt + 1;
      if (sl_cnt > sl_delay) sl_ack_n = 2'b00;
      if (!bus_ds_n && !bus_rw && bus_dout_en) begin
        for (int b = 0; b < 4; b++) begin
          if (!bus_we_n[b]) mem[bus_addr[5:2]][8*b +: 8] = bus_dout[8*b +: 8];
        end
      end
    end else begin
      sl_cnt   = 0;
      sl_ack_n = 2'b11;
    end
  end

  // ---------------- bus monitor ----------------
  int   as_falls = 0, as_low = 0, lock_low = 0, unlocked_busy = 0;
  logic prev_as = 1'b1;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_as && !bus_as_n) as_falls = as_falls + 1;
      if (!bus_as_n) as_low = as_low + 1;
      if (!bus_lock_n) lock_low = lock_low + 1;
      if (!req_ready && bus_lock_n) unlocked_busy = unlocked_busy + 1;
    end
    prev_as = bus_as_n;
  end

  // ---------------- bookkeeping ----------------
  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
  end

  task automatic preload(input logic [3:0] idx, input logic [31:0] val);
    @(posedge clk);
    ld_idx = idx; ld_val = val; ld_go = 1'b1;
    @(posedge clk);
    ld_go = 1'b0;
  endtask

  task automatic wait_done(output logic [31:0] rd);
    int t = 0;
    rd = '0;
    while (!done_o && t < 1000) begin
      @(negedge clk);
      t++;
    end
    if (!done_o) chk("R9 done timeout", 32'd0, 32'd1);
    rd = rdata_o;
  endtask

  // request issue; optional intruding request while busy
  int d_falls, d_low, d_lock, d_unl;
  task automatic run_req(input logic [1:0] kind, input logic [3:0] idx,
                         input logic [31:0] opnd, input logic [3:0] lanes,
                         input int delay, input bit intrude,
                         output logic [31:0] rd);
    int f0, l0, k0, u0;
    sl_delay = delay;
    @(negedge clk);
    f0 = as_falls; l0 = as_low; k0 = lock_low; u0 = unlocked_busy;
    req_kind = kind; req_addr = AW'({idx, 2'b00}); req_wdata = opnd;
    req_lanes = lanes; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (intrude) begin
      for (int k = 0; k < 3; k++) begin
        chk("R2 ready low while busy", 32'(req_ready), 32'd0);
        req_kind = 2'd1; req_addr = AW'({4'd9, 2'b00});
        req_wdata = 32'h5555_5555; req_lanes = 4'hF; req_valid = 1'b1;
        @(negedge clk);
      end
      req_valid = 1'b0;
    end
    wait_done(rd);
    d_falls = as_falls - f0; d_low = as_low - l0;
    d_lock = lock_low - k0;  d_unl = unlocked_busy - u0;
  endtask

  typedef struct packed {
    logic [1:0]  kind;
    logic [3:0]  idx;
    logic [31:0] opnd;
    logic [3:0]  lanes;
    logic [3:0]  delay;
    logic [31:0] init;
    logic [31:0] exp_rd;
    logic [31:0] exp_mem;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 4'd1, 32'h0,         4'h0, 4'd1, 32'h1234_5678, 32'h1234_5678, 32'h1234_5678},
    '{2'd1, 4'd2, 32'h1122_3344, 4'hF, 4'd2, 32'hAAAA_AAAA, 32'h0,         32'h1122_3344},
    '{2'd1, 4'd3, 32'h0,         4'h5, 4'd0, 32'hFFFF_FFFF, 32'h0,         32'hFF00_FF00},
    '{2'd2, 4'd4, 32'h0000_000F, 4'hF, 4'd3, 32'h0000_00F0, 32'h0000_00F0, 32'h0000_00FF},
    '{2'd2, 4'd5, 32'h0F0F_0F0F, 4'h8, 4'd1, 32'h8000_0001, 32'h8000_0001, 32'h8F00_0001},
    '{2'd0, 4'd6, 32'h0,         4'h0, 4'd6, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
    '{2'd2, 4'd7, 32'hFFFF_FFFF, 4'h3, 4'd0, 32'h0000_0000, 32'h0000_0000, 32'h0000_FFFF}
  };

  initial begin
    logic [31:0] rd;
    int low_fast, low_slow;
    low_fast = 0; low_slow = 0;
    for (int i = 0; i < 16; i++) mem[i] = 32'h0;

    // R1: idle state under reset
    repeat (3) @(negedge clk);
    chk("R1 as_n", 32'(bus_as_n), 32'd1);
    chk("R1 ds_n/oe_n", {30'd0, bus_ds_n, bus_oe_n}, 32'd3);
    chk("R1 we_n", 32'(bus_we_n), 32'hF);
    chk("R1 rw/lock_n", {30'd0, bus_rw, bus_lock_n}, 32'd3);
    chk("R1 dout_en/done", {30'd0, bus_dout_en, done_o}, 32'd0);
    chk("R1 ready", 32'(req_ready), 32'd1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // vector table: R3 R4 R5 R6 R7 R8
    for (int v = 0; v < NV; v++) begin
      preload(VEC[v].idx, VEC[v].init);
      run_req(VEC[v].kind, VEC[v].idx, VEC[v].opnd, VEC[v].lanes,
              int'(VEC[v].delay), 1'b0, rd);
      if (VEC[v].kind != 2'd1) chk("R3 read data", rd, VEC[v].exp_rd);
      chk("R7 memory word after request", mem[VEC[v].idx], VEC[v].exp_mem);
      if (VEC[v].kind == 2'd2) begin
        chk("R6 two strobes in locked pair", 32'(d_falls), 32'd2);
        chk("R6 lock held while busy", 32'(d_unl), 32'd0);
      end else begin
        chk("R8 single strobe", 32'(d_falls), 32'd1);
        chk("R8 no lock", 32'(d_lock), 32'd0);
      end
      if (v == 0) low_fast = d_low;
      if (v == 5) low_slow = d_low;
      @(negedge clk);
      chk("R9 done is one cycle", 32'(done_o), 32'd0);
    end
    // R5: slower responder stretches the strobe
    chk("R5 wait ticks grow with delay", 32'(low_slow > low_fast + 3), 32'd1);

    // R2: intruding request while busy is ignored
    preload(4'd9, 32'h9999_9999);
    preload(4'd8, 32'h0);
    run_req(2'd2, 4'd8, 32'h1, 4'hF, 2, 1'b1, rd);
    chk("R2 intruder left memory alone", mem[9], 32'h9999_9999);
    chk("R2 only own strobes", 32'(d_falls), 32'd2);
    chk("R7 own word written", mem[8], 32'h1);

    // R10: single-cycle acknowledge glitch is ignored
    preload(4'd10, 32'hCAFE_F00D);
    slave_en = 1'b0;
    @(negedge clk);
    req_kind = 2'd0; req_addr = AW'({4'd10, 2'b00}); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (4) @(negedge clk);
    man_ack_n = 2'b00;
    @(negedge clk);
    man_ack_n = 2'b11;
    repeat (8) @(negedge clk);
    chk("R10 glitch did not end cycle", 32'(bus_as_n), 32'd0);
    man_ack_n = 2'b00;
    wait_done(rd);
    man_ack_n = 2'b11;
    chk("R10 read after real ack", rd, 32'hCAFE_F00D);
    slave_en = 1'b1;
    repeat (4) @(negedge clk);

    summary();
  end

endmodule